// File: doc/BRIEF.md
# SPI Serial Memory Slave Engine

This block is the slave side of a mode-0 SPI link in front of a 256-byte memory. The serial pins (clock, select, hold and data in) are sampled by a faster system clock through two-flop synchronizers, and edges are found on the synchronized levels. Each frame opens with an 8-bit instruction. The engine understands four instructions: latch-enable, latch-clear, read and write. Everything on the wire is most-significant bit first.

A read takes one address byte and then streams data bytes for as long as the host keeps clocking. The address advances after every byte and wraps over the whole space. A write, when the enable latch is set, takes an address byte and then hands each completed data byte to the byte array through a one-cycle strobe with address and data. The write address steps inside an aligned 4-byte page. A hold input can pause a frame in the middle without losing its place. While the frame is paused, and whenever the device is deselected, the data output driver is switched off.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset every array byte reads 0x00, the enable latch is clear and so_en_o is low. The engine stays idle until it sees a falling edge on cs_ni.
- R2: SI is sampled on rising SCK and SO changes only after falling SCK. Opcode, address and data are all sent MSB first.
- R3: Opcode 0x03 followed by an address byte makes the engine shift out the byte at that address, then the following bytes in order, for as long as SCK runs.
- R4: During a read the address wraps from 0xFF to 0x00.
- R5: Opcode 0x06 sets the enable latch. Any bits clocked after it in the same frame are ignored. With the latch set, opcode 0x02, an address byte and N data bytes store those bytes. When a frame that stored at least one byte ends, the latch clears.
- R6: Opcode 0x04 clears the enable latch. A write frame sent while the latch is clear leaves the array unchanged.
- R7: During a write the address advances only in its two low bits, so a write wraps inside its aligned 4-byte page. Later bytes overwrite earlier ones.
- R8: While cs_ni is high, so_en_o is low and the command state is reset. A frame cut off part-way has no effect on the next frame.
- R9: While paused by hold, so_en_o is low and SCK and SI are ignored. When hold is released the frame continues from the exact bit where it stopped.
- R10: A change on hold_ni is taken only while SCK is low. A change made while SCK is high waits for SCK to go low.
- R11: An opcode outside the four defined ones makes the rest of the frame ignored: nothing is written, the latch is unchanged and so_en_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| si_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out |
| so_en_o | output | 1 | Output driver enable; low means SO is high impedance |

## Verification
The checker watches several rules on every clock. SO stays quiet while deselected or paused. SO moves only in the cycle after an accepted falling SCK. A pause begins or ends only while the synchronized SCK is low. No write strobe fires without the enable latch, or in the cycle after the device was deselected. Whether data is correct, and what depends on the order of events, only the bench scenarios can show. That covers address increment and full-space wrap on reads, page wrap on writes, the latch life cycle, aborted and unknown frames, and resuming after a hold taken at different points in a byte.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPC,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_SKIP
  } eng_state_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
  parameter int                W       = 4,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  input  logic cs_s_i,
  input  logic hold_s_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic paused_o
);
  logic sck_q, cs_q, paused_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q    <= 1'b0;
      cs_q     <= 1'b1;
      paused_q <= 1'b0;
    end else begin
      sck_q <= sck_s_i;
      cs_q  <= cs_s_i;
      if (cs_s_i)        paused_q <= 1'b0;
      else if (!sck_s_i) paused_q <= ~hold_s_i;  // hold changes only with SCK low
    end
  end

  assign sck_rise_o = sck_s_i & ~sck_q & ~paused_q & ~cs_s_i;
  assign sck_fall_o = ~sck_s_i & sck_q & ~paused_q & ~cs_s_i;
  assign cs_fall_o  = ~cs_s_i & cs_q;
  assign paused_o   = paused_q;
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_stb_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_stb_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spi_mem_engine.sv
module spi_mem_engine
  import spi_mem_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int PAGE  = 4,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DW),
  localparam int PW   = $clog2(PAGE)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_s_i,
  input  logic          cs_fall_i,
  input  logic          sck_rise_i,
  input  logic          sck_fall_i,
  input  logic          si_s_i,
  input  logic [DW-1:0] rd_data_i,
  output logic [AW-1:0] rd_addr_o,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          so_o,
  output logic          so_drv_o,
  output logic          wel_o
);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  eng_state_e    st_q;
  logic [CW-1:0] bit_q;
  logic [DW-1:0] sh_q, out_q;
  logic [AW-1:0] addr_q, page_nxt;
  logic          rd_q, wel_q, wr_any_q, so_q, drv_q;
  logic          wr_stb_q;
  logic [AW-1:0] wr_addr_q;
  logic [DW-1:0] wr_data_q;
  logic [DW-1:0] byte_in;

  assign byte_in = {sh_q[DW-2:0], si_s_i};

  generate
    if (PW == 0) begin : g_nopage
      assign page_nxt = addr_q;
    end else begin : g_page
      assign page_nxt = {addr_q[AW-1:PW], addr_q[PW-1:0] + 1'b1};
    end
  endgenerate

  // fetch for the byte that will be loaded at the next byte boundary
  assign rd_addr_o = (st_q == ST_ADDR) ? byte_in[AW-1:0] : addr_q + AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_q     <= '0;
      sh_q      <= '0;
      out_q     <= '0;
      addr_q    <= '0;
      rd_q      <= 1'b0;
      wel_q     <= 1'b0;
      wr_any_q  <= 1'b0;
      so_q      <= 1'b0;
      drv_q     <= 1'b0;
      wr_stb_q  <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_stb_q <= 1'b0;
      if (cs_s_i) begin
        st_q  <= ST_IDLE;
        bit_q <= '0;
        drv_q <= 1'b0;
        so_q  <= 1'b0;
        if (wr_any_q) begin
          wel_q    <= 1'b0;
          wr_any_q <= 1'b0;
        end
      end else if (cs_fall_i) begin
        st_q  <= ST_OPC;
        bit_q <= '0;
      end else if (sck_rise_i && st_q != ST_IDLE && st_q != ST_SKIP) begin
        sh_q  <= byte_in;
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST) begin
          unique case (st_q)
            ST_OPC: begin
              if (byte_in[7:0] == OP_WREN) begin
                wel_q <= 1'b1;
                st_q  <= ST_SKIP;
              end else if (byte_in[7:0] == OP_WRDI) begin
                wel_q <= 1'b0;
                st_q  <= ST_SKIP;
              end else if (byte_in[7:0] == OP_READ) begin
                rd_q <= 1'b1;
                st_q <= ST_ADDR;
              end else if (byte_in[7:0] == OP_WRITE) begin
                rd_q <= 1'b0;
                st_q <= ST_ADDR;
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              addr_q <= byte_in[AW-1:0];
              if (rd_q) begin
                st_q  <= ST_RD;
                out_q <= rd_data_i;
              end else if (wel_q) begin
                st_q <= ST_WR;
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_RD: begin
              addr_q <= addr_q + AW'(1);
              out_q  <= rd_data_i;
            end
            ST_WR: begin
              wr_stb_q  <= 1'b1;
              wr_addr_q <= addr_q;
              wr_data_q <= byte_in;
              addr_q    <= page_nxt;
              wr_any_q  <= 1'b1;
            end
            default: st_q <= ST_SKIP;
          endcase
        end
      end else if (sck_fall_i && st_q == ST_RD) begin
        so_q  <= out_q[DW-1];
        out_q <= {out_q[DW-2:0], 1'b0};
        drv_q <= 1'b1;
      end
    end
  end

  assign wr_stb_o  = wr_stb_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign so_o      = so_q;
  assign so_drv_o  = drv_q;
  assign wel_o     = wel_q;
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int DEPTH = 256,
  parameter int DW    = 8,
  parameter int PAGE  = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_en_o
);
  logic cs_s, sck_s, si_s, hold_s;
  logic sck_rise, sck_fall, cs_fall, paused;
  logic so_drv, wel;
  logic wr_stb;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  spi_mem_sync #(.W(4), .RST_VAL(4'b1010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sck_i, hold_ni, si_i}),
    .q_o   ({cs_s, sck_s, hold_s, si_s})
  );

  spi_mem_frontend u_front (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .cs_s_i    (cs_s),
    .hold_s_i  (hold_s),
    .sck_rise_o(sck_rise),
    .sck_fall_o(sck_fall),
    .cs_fall_o (cs_fall),
    .paused_o  (paused)
  );

  spi_mem_engine #(.DEPTH(DEPTH), .DW(DW), .PAGE(PAGE)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_s_i    (cs_s),
    .cs_fall_i (cs_fall),
    .sck_rise_i(sck_rise),
    .sck_fall_i(sck_fall),
    .si_s_i    (si_s),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .wr_stb_o  (wr_stb),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .so_o      (so_o),
    .so_drv_o  (so_drv),
    .wel_o     (wel)
  );

  spi_mem_array #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  assign so_en_o = so_drv & ~cs_s & ~paused;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic sck_s,
  input logic sck_fall,
  input logic paused,
  input logic so_o,
  input logic so_en_o,
  input logic wr_stb,
  input logic wel
);
  p_hiz_deselect_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> !so_en_o);

  p_hiz_paused_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused |-> !so_en_o);

  p_so_after_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_en_o && $past(so_en_o) && !$past(sck_fall)) |-> $stable(so_o));

  p_pause_sck_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paused != $past(paused)) |-> !$past(sck_s));

  p_write_needs_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |-> wel);

  p_no_write_deselected_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stb |-> !$past(cs_s));
endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_s    (cs_s),
  .sck_s   (sck_s),
  .sck_fall(sck_fall),
  .paused  (paused),
  .so_o    (so_o),
  .so_en_o (so_en_o),
  .wr_stb  (wr_stb),
  .wel     (wel)
);

// File: tb/spi_mem_slave_bench.sv
module spi_mem_slave_bench;
  localparam int H = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
  logic so, so_en;

  int n_chk = 0, n_fail = 0;
  logic [7:0] ref_mem [256];
  bit wel_ref = 1'b0;

  always #2 clk = ~clk;

  spi_mem_slave u_spi_mem_slave (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .cs_ni  (cs_n),
    .sck_i  (sck),
    .si_i   (si),
    .hold_ni(hold_n),
    .so_o   (so),
    .so_en_o(so_en)
  );

  function automatic logic [7:0] page_next(input logic [7:0] a);
    return {a[7:2], a[1:0] + 2'd1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_h(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bit_io(input logic b, output logic so_v, output logic en_v);
    si = b;
    wait_h(H);
    so_v = so;
    en_v = so_en;
    sck  = 1'b1;
    wait_h(H / 2);
    if (en_v) chk(so === so_v, "R2 SO steady over rising SCK", so, so_v);
    wait_h(H - H / 2);
    sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, output bit any_en);
    logic s, e;
    any_en = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_io(tx[i], s, e);
      rx[i] = s;
      any_en |= e;
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    wait_h(H);
  endtask

  task automatic cs_off();
    wait_h(H);
    cs_n = 1'b1;
    wait_h(H);
    chk(so_en == 1'b0, "R8 SO off when deselected", so_en, 0);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx;
    bit e;
    cs_on();
    xfer(op, rx, e);
    cs_off();
    if (op == 8'h06) wel_ref = 1'b1;
    if (op == 8'h04) wel_ref = 1'b0;
  endtask

  task automatic wr_frame(input logic [7:0] addr, input int n, input logic [7:0] seed);
    logic [7:0] rx, a, d;
    bit e;
    cs_on();
    xfer(8'h02, rx, e);
    xfer(addr, rx, e);
    a = addr;
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 37);
      xfer(d, rx, e);
      if (wel_ref) ref_mem[a] = d;
      a = page_next(a);
    end
    cs_off();
    if (wel_ref && n > 0) wel_ref = 1'b0;
  endtask

  task automatic rd_frame(input logic [7:0] addr, input int n, input string tag);
    logic [7:0] rx, a;
    bit e;
    cs_on();
    xfer(8'h03, rx, e);
    xfer(addr, rx, e);
    a = addr;
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, rx, e);
      chk(e && rx == ref_mem[a], tag, {23'd0, e, rx}, {24'd1, ref_mem[a]});
      a = a + 8'd1;
    end
    cs_off();
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rx, rb;
    logic s, e;
    bit any;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    wait_h(4);
    rst_n = 1'b1;
    wait_h(4);

    // R1: reset state
    chk(so_en == 1'b0, "R1 SO off after reset", so_en, 0);
    wr_frame(8'h05, 1, 8'h99);  // latch clear after reset, must not store
    rd_frame(8'h04, 3, "R1 array zero and latch clear after reset");

    // R5: latch then single byte write; latch auto clears
    cmd(8'h06);
    wr_frame(8'h05, 1, 8'h3C);
    rd_frame(8'h05, 1, "R5 byte stored with latch set");
    wr_frame(8'h05, 1, 8'h11);
    rd_frame(8'h05, 1, "R5 latch cleared after write frame");

    // R6: WRDI clears latch
    cmd(8'h06);
    cmd(8'h04);
    wr_frame(8'h30, 2, 8'hA0);
    rd_frame(8'h30, 2, "R6 write ignored after latch clear");

    // R7: page wrap on write
    cmd(8'h06);
    wr_frame(8'h42, 6, 8'h51);
    rd_frame(8'h40, 4, "R7 write wraps within page");

    // R3 / R4: streaming read and full-space wrap
    cmd(8'h06);
    wr_frame(8'hFE, 2, 8'hC1);
    cmd(8'h06);
    wr_frame(8'h00, 2, 8'hD7);
    rd_frame(8'h3E, 8, "R3 sequential read with increment");
    rd_frame(8'hFE, 4, "R4 read wraps from FF to 00");

    // R8: aborted opcode then clean frame
    cs_on();
    for (int i = 0; i < 4; i++) bit_io(1'b0, s, e);
    cs_off();
    rd_frame(8'h42, 2, "R8 aborted frame has no effect");

    // R11: unknown opcode ignores rest of frame
    cmd(8'h06);
    cs_on();
    xfer(8'hA5, rx, any);
    chk(!any, "R11 SO off after unknown opcode", any, 0);
    xfer(8'h02, rx, any);
    xfer(8'h10, rx, any);
    xfer(8'h77, rx, any);
    chk(!any, "R11 SO stays off in ignored frame", any, 0);
    cs_off();
    rd_frame(8'h10, 1, "R11 no write from ignored frame");
    // latch still set: a write must now land
    wr_frame(8'h12, 1, 8'h6E);
    rd_frame(8'h12, 1, "R11 latch untouched by unknown opcode");

    // R5: bits after WREN in same frame ignored
    cs_on();
    xfer(8'h06, rx, any);
    xfer(8'h02, rx, any);
    xfer(8'h20, rx, any);
    xfer(8'h55, rx, any);
    cs_off();
    wel_ref = 1'b1;
    rd_frame(8'h20, 1, "R5 write after WREN in same frame ignored");
    cmd(8'h04);

    // R9: hold mid data byte with junk clocks
    cs_on();
    xfer(8'h03, rx, any);
    xfer(8'h40, rx, any);
    xfer(8'h00, rx, any);
    chk(rx == ref_mem[8'h40], "R9 byte before hold", rx, ref_mem[8'h40]);
    for (int i = 7; i >= 5; i--) begin
      bit_io(1'b0, s, e);
      rb[i] = s;
    end
    hold_n = 1'b0;
    wait_h(H);
    chk(so_en == 1'b0, "R9 SO off while paused", so_en, 0);
    for (int i = 0; i < 3; i++) begin
      si = 1'($urandom);
      sck = 1'b1;
      wait_h(H);
      sck = 1'b0;
      wait_h(H);
      chk(so_en == 1'b0, "R9 SO off during ignored clocks", so_en, 0);
    end
    hold_n = 1'b1;
    wait_h(H);
    chk(so_en == 1'b1, "R9 SO back on after release", so_en, 1);
    for (int i = 4; i >= 0; i--) begin
      bit_io(1'b0, s, e);
      rb[i] = s;
    end
    chk(rb == ref_mem[8'h41], "R9 byte resumes across hold", rb, ref_mem[8'h41]);
    xfer(8'h00, rx, any);
    chk(rx == ref_mem[8'h42], "R9 following byte intact", rx, ref_mem[8'h42]);
    cs_off();

    // R10: hold edges taken only with SCK low
    cs_on();
    xfer(8'h03, rx, any);
    xfer(8'h41, rx, any);
    for (int i = 7; i >= 4; i--) begin
      bit_io(1'b0, s, e);
      rb[i] = s;
    end
    si = 1'b0;
    wait_h(H);
    rb[3] = so;
    sck = 1'b1;
    wait_h(H);
    hold_n = 1'b0;
    wait_h(H);
    chk(so_en == 1'b1, "R10 hold ignored while SCK high", so_en, 1);
    chk(so == rb[3], "R10 SO steady while SCK high", so, rb[3]);
    sck = 1'b0;
    wait_h(H);
    chk(so_en == 1'b0, "R10 pause taken once SCK low", so_en, 0);
    sck = 1'b1;
    wait_h(H);
    hold_n = 1'b1;
    wait_h(H);
    chk(so_en == 1'b0, "R10 release waits for SCK low", so_en, 0);
    sck = 1'b0;
    wait_h(H);
    chk(so_en == 1'b1, "R10 release taken once SCK low", so_en, 1);
    for (int i = 2; i >= 0; i--) begin
      bit_io(1'b0, s, e);
      rb[i] = s;
    end
    chk(rb == ref_mem[8'h41], "R10 byte intact across hold", rb, ref_mem[8'h41]);
    xfer(8'h00, rx, any);
    chk(rx == ref_mem[8'h42], "R10 next byte intact", rx, ref_mem[8'h42]);
    cs_off();

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      case ($urandom % 3)
        0: begin
          n = 1 + int'($urandom % 6);
          cmd(8'h06);
          wr_frame(a, n, 8'($urandom));
        end
        1: begin
          n = 1 + int'($urandom % 5);
          rd_frame(a, n, "R3 random read");
        end
        default: begin
          cmd(8'h04);
          wr_frame(a, 2, 8'($urandom));
          rd_frame(a, 2, "R6 random write with latch clear");
        end
      endcase
    end
    rd_frame(8'hF8, 16, "R4 final sweep across wrap");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule